// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers a 32-bit bus address to one of eight address windows that software programs. Each window has a control word (size mask, target identifier, attribute code, enable) and a base address. The lower-numbered windows also carry a low and a high remap word. When an address arrives with its valid strobe, the block finds the window that matches it. On the next clock edge it reports a hit or a miss, the index of the matching window, that window's target and attribute, and the translated address.

Window sizes are powers of two in units of 64 KB. The size field holds a contiguous run of ones starting at bit 0. Each one doubles the window, and an all-zero field gives the smallest window of 64 KB. On a remap-capable window, the translated address takes its upper bits from the remap-low word and its lower bits from the incoming address. Software turns translation off by writing the base value into remap-low. All other windows pass the address through unchanged. A simple write strobe with combinational read data gives access to every register.

The decision is held in a registered result state with three values: RES_IDLE (no result this cycle), RES_HIT and RES_MISS. The next state is RES_IDLE when the valid strobe is low. When the strobe is high it is RES_HIT if any window matches, otherwise RES_MISS.

Top module: `addr_win_decoder`

## Requirements
- R1: A window matches when its enable bit is set and in_addr[31:16], masked by the inverted size field, equals base[31:16] masked the same way. in_addr[15:0] is never compared and always appears unchanged in out_addr[15:0].
- R2: A size field with N contiguous low ones makes a window of 2^N × 64 KB. A size of 0x0000 covers exactly one 64 KB page.
- R3: When several windows match, the lowest-numbered one is reported.
- R4: When no window matches, out_miss=1, out_hit=0, out_idx=0, out_target=0, out_attr=0 and out_addr=in_addr.
- R5: A window whose enable bit is clear never matches, whatever its base and size.
- R6: Reset clears every register, so all control words read 0 and every access misses until software programs a window.
- R7: Windows 0 to 3 translate the address: out_addr = (remap_lo & ~M) | (in_addr & M), where M = {size, 16'hFFFF}.
- R8: When remap_lo equals base on windows 0 to 3, out_addr equals in_addr.
- R9: Windows 4 to 7 return in_addr unchanged. Their remap registers read 0 and ignore writes.
- R10: Each result appears with out_valid=1 on the clock edge after the edge that sampled in_valid=1. out_valid is 0 in every other cycle.
- R11: Register select values are 0 control, 1 base, 2 remap-low and 3 remap-high. The control word layout is size[15:0], target[19:16], attribute[27:20] and enable[31], with bits 30:28 reading 0. Base and remap-low store bits 31:16 only and read 0 in bits 15:0. Remap-high stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window selected for register access |
| cfg_reg | input | 2 | Register selected within the window |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| in_valid | input | 1 | Address valid strobe |
| in_addr | input | 32 | Address to decode |
| out_valid | output | 1 | A decode result is present |
| out_hit | output | 1 | The address matched a window |
| out_miss | output | 1 | The address matched no window |
| out_idx | output | 3 | Index of the winning window |
| out_target | output | 4 | Target identifier of the winning window |
| out_attr | output | 8 | Attribute code of the winning window |
| out_addr | output | 32 | Translated address |

## Verification
The bench targets the following corner cases.
- The first page past a minimum-size window must miss. A decoder that reads size zero as "no window" or as a larger window would report a false hit, or miss the first page instead.
- Two overlapping windows must resolve to the lower index. Reversed priority would return the higher window's target.
- A fully masked window that is disabled must stay silent. Once enabled, it must still lose to lower windows. A faulty enable would take over the whole address space.
- Remap-low and base are given different values at the edge of a 256 KB window. The remap-low write to a non-remap window, and the identity setting, are exercised too. A wrong mask split, or a remap applied to a non-remap window, would corrupt out_addr.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int AW     = 32;
    localparam int PAGE_W = 16;
    localparam int UP_W   = AW - PAGE_W;
    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_RLO  = 2'd2,
        REG_RHI  = 2'd3
    } awd_reg_e;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } awd_res_e;

    typedef struct packed {
        logic              en;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  tgt;
        logic [UP_W-1:0]   size;
    } awd_ctrl_t;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_win,
    input  awd_reg_e         cfg_reg,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    output awd_ctrl_t        ctrl_o [NUM_WIN],
    output logic [UP_W-1:0]  base_o [NUM_WIN],
    output logic [UP_W-1:0]  rlo_o  [NUM_WIN]
);
    logic [AW-1:0] rhi [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic sel_w;
        assign sel_w = cfg_wr && (cfg_win == IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_o[w] <= '0;
                base_o[w] <= '0;
            end else if (sel_w && cfg_reg == REG_CTRL) begin
                ctrl_o[w] <= '{en:   cfg_wdata[31],
                               attr: cfg_wdata[27:20],
                               tgt:  cfg_wdata[19:16],
                               size: cfg_wdata[15:0]};
            end else if (sel_w && cfg_reg == REG_BASE) begin
                base_o[w] <= cfg_wdata[AW-1:PAGE_W];
            end
        end

        if (w < NUM_REMAP) begin : g_remap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rlo_o[w] <= '0;
                    rhi[w]   <= '0;
                end else if (sel_w && cfg_reg == REG_RLO) begin
                    rlo_o[w] <= cfg_wdata[AW-1:PAGE_W];
                end else if (sel_w && cfg_reg == REG_RHI) begin
                    rhi[w] <= cfg_wdata;
                end
            end
        end else begin : g_noremap
            assign rlo_o[w] = '0;
            assign rhi[w]   = '0;
        end
    end

    always_comb begin
        unique case (cfg_reg)
            REG_CTRL: cfg_rdata = {ctrl_o[cfg_win].en, 3'b000, ctrl_o[cfg_win].attr,
                                   ctrl_o[cfg_win].tgt, ctrl_o[cfg_win].size};
            REG_BASE: cfg_rdata = {base_o[cfg_win], {PAGE_W{1'b0}}};
            REG_RLO:  cfg_rdata = {rlo_o[cfg_win], {PAGE_W{1'b0}}};
            REG_RHI:  cfg_rdata = rhi[cfg_win];
            default:  cfg_rdata = '0;
        endcase
    end

    // R11: a control write is visible on the read port one cycle later
    p_ctrl_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_reg == REG_CTRL) |=>
        (ctrl_o[$past(cfg_win)].size == $past(cfg_wdata[15:0])));
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [AW-1:0]      addr,
    input  awd_ctrl_t          ctrl_i [NUM_WIN],
    input  logic [UP_W-1:0]    base_i [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec
);
    logic [UP_W-1:0] page;
    assign page = addr[AW-1:PAGE_W];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign hit_vec[w] = ctrl_i[w].en &&
            ((page & ~ctrl_i[w].size) == (base_i[w] & ~ctrl_i[w].size));
    end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_reg,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              in_valid,
    input  logic [AW-1:0]     in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_miss,
    output logic [IDX_W-1:0]  out_idx,
    output logic [TGT_W-1:0]  out_target,
    output logic [ATTR_W-1:0] out_attr,
    output logic [AW-1:0]     out_addr
);
    awd_ctrl_t          ctrl   [NUM_WIN];
    logic [UP_W-1:0]    base   [NUM_WIN];
    logic [UP_W-1:0]    rlo    [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] en_vec;

    awd_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_win(cfg_win),
        .cfg_reg(awd_reg_e'(cfg_reg)), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl_o(ctrl), .base_o(base), .rlo_o(rlo)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr(in_addr), .ctrl_i(ctrl), .base_i(base), .hit_vec(hit_vec)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_en
        assign en_vec[w] = ctrl[w].en;
    end

    // lowest index wins
    logic [IDX_W-1:0] win_idx;
    logic             found;
    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    logic [AW-1:0] mask;
    logic [AW-1:0] xaddr;
    always_comb begin
        mask = {ctrl[win_idx].size, {PAGE_W{1'b1}}};
        if (found && int'(win_idx) < NUM_REMAP)
            xaddr = ({rlo[win_idx], {PAGE_W{1'b0}}} & ~mask) | (in_addr & mask);
        else
            xaddr = in_addr;
    end

    // result state register
    awd_res_e         res_q, res_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    addr_q;

    always_comb begin
        if (!in_valid)  res_d = RES_IDLE;
        else if (found) res_d = RES_HIT;
        else            res_d = RES_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= RES_IDLE;
            idx_q  <= '0;
            addr_q <= '0;
        end else begin
            res_q  <= res_d;
            idx_q  <= found ? win_idx : '0;
            addr_q <= xaddr;
        end
    end

    // output process
    always_comb begin
        out_valid  = 1'b0;
        out_hit    = 1'b0;
        out_miss   = 1'b0;
        out_idx    = '0;
        out_target = '0;
        out_attr   = '0;
        out_addr   = addr_q;
        unique case (res_q)
            RES_IDLE: ;
            RES_HIT: begin
                out_valid  = 1'b1;
                out_hit    = 1'b1;
                out_idx    = idx_q;
                out_target = ctrl[idx_q].tgt;
                out_attr   = ctrl[idx_q].attr;
            end
            RES_MISS: begin
                out_valid = 1'b1;
                out_miss  = 1'b1;
            end
            default: ;
        endcase
    end

    p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_target == '0 && out_attr == '0 && out_addr == $past(in_addr)));
    p_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> |($past(en_vec) & (NUM_WIN'(1) << out_idx)));
    p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (($past(hit_vec) & ((NUM_WIN'(1) << out_idx) - NUM_WIN'(1))) == '0));
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit && int'(out_idx) >= NUM_REMAP) |-> out_addr == $past(in_addr));
    p_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[PAGE_W-1:0] == $past(in_addr[PAGE_W-1:0]));
endmodule

// File: tb/tb_addr_win_decoder.sv
module tb_addr_win_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [2:0]  out_idx;
    logic [3:0]  out_target;
    logic [7:0]  out_attr;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_win_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_win(cfg_win),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
        .out_hit(out_hit), .out_miss(out_miss), .out_idx(out_idx),
        .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr)
    );

    // {addr, hit, idx, target, attr, out_addr}
    localparam int NV = 12;
    localparam logic [79:0] VEC [NV] = '{
        {32'h8000_0010, 1'b1, 3'd0, 4'h4, 8'hE8, 32'h8000_0010}, // R3 R8
        {32'h8FFF_FFFF, 1'b1, 3'd0, 4'h4, 8'hE8, 32'h8FFF_FFFF}, // R1 R8
        {32'h9000_1234, 1'b1, 3'd1, 4'h4, 8'hE0, 32'hC000_1234}, // R7 R2
        {32'h9001_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h9001_0000}, // R2 R4
        {32'hDABC_DEF0, 1'b1, 3'd2, 4'h1, 8'h2F, 32'h12BC_DEF0}, // R7
        {32'hB003_FFFC, 1'b1, 3'd3, 4'h2, 8'h55, 32'h2003_FFFC}, // R7 R2
        {32'hB004_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'hB004_0000}, // R2 R4
        {32'hE0AB_0000, 1'b1, 3'd4, 4'h1, 8'h0F, 32'hE0AB_0000}, // R9
        {32'hE000_0004, 1'b1, 3'd4, 4'h1, 8'h0F, 32'hE000_0004}, // R3
        {32'hF000_ABCD, 1'b1, 3'd5, 4'h3, 8'h01, 32'hF000_ABCD}, // R9
        {32'hA000_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'hA000_0000}, // R5
        {32'h7FFF_FFFF, 1'b0, 3'd0, 4'h0, 8'h00, 32'h7FFF_FFFF}  // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int w, input int r, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_win = 3'(w); cfg_reg = 2'(r); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int w, input int r, output logic [31:0] d);
        @(negedge clk);
        cfg_win = 3'(w); cfg_reg = 2'(r);
        #1 d = cfg_rdata;
    endtask

    // result sampled at the negedge after the capturing posedge
    task automatic access(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic hit, input int idx,
                              input int tgt, input int attr, input logic [31:0] xa);
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, {30'd0, out_hit, out_miss}, {30'd0, hit, ~hit});
        chk(req, {17'd0, out_idx, out_target, out_attr},
            {17'd0, 3'(idx), 4'(tgt), 8'(attr)});
        chk(req, out_addr, xa);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        chk("R6 out_valid", {31'd0, out_valid}, 32'd0);
        rd(0, 0, d); chk("R6 ctrl0", d, 32'd0);
        rd(7, 0, d); chk("R6 ctrl7", d, 32'd0);
        access(32'h0000_0000);
        expect_res("R6 miss at zero", 1'b0, 0, 0, 0, 32'h0000_0000);
        access(32'h8000_0010);
        expect_res("R6 miss before program", 1'b0, 0, 0, 0, 32'h8000_0010);

        // program: ctrl = en<<31 | attr<<20 | tgt<<16 | size
        wr(0, 1, 32'h8000_0000); wr(0, 2, 32'h8000_0000);
        wr(0, 0, 32'h8E84_0FFF); wr(0, 3, 32'hDEAD_BEEF);
        wr(1, 1, 32'h9000_0000); wr(1, 2, 32'hC000_0000);
        wr(1, 0, 32'h8E04_0000);
        wr(2, 1, 32'hD800_1234); wr(2, 2, 32'h1000_0000);
        wr(2, 0, 32'h82F1_07FF);
        wr(3, 1, 32'hB000_0000); wr(3, 2, 32'h2000_FFFF);
        wr(3, 0, 32'h8552_0003);
        wr(4, 1, 32'hE000_0000); wr(4, 2, 32'h1234_0000);
        wr(4, 0, 32'h80F1_00FF);
        wr(5, 1, 32'hF000_0000); wr(5, 0, 32'h8013_0000);
        wr(6, 1, 32'hE000_0000); wr(6, 0, 32'h8332_0000);
        wr(7, 1, 32'hA000_0000); wr(7, 0, 32'h0775_FFFF); // disabled, full mask

        // R11 readback
        rd(2, 0, d); chk("R11 ctrl2", d, 32'h82F1_07FF);
        rd(2, 1, d); chk("R11 base low bits", d, 32'hD800_0000);
        rd(0, 3, d); chk("R11 remap hi", d, 32'hDEAD_BEEF);
        rd(3, 2, d); chk("R11 remap lo", d, 32'h2000_0000);
        rd(4, 2, d); chk("R9 no remap lo", d, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][79:48]);
            expect_res($sformatf("vector %0d", i), VEC[i][47], int'(VEC[i][46:44]),
                       int'(VEC[i][43:40]), int'(VEC[i][39:32]), VEC[i][31:0]);
        end

        // R10 one-cycle pulse
        access(32'hF000_0000);
        @(negedge clk);
        chk("R10 valid drops", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R10 stays idle", {31'd0, out_valid}, 32'd0);

        // R5 then enable full-mask window 7; lower windows still win (R3)
        wr(7, 0, 32'h8775_FFFF);
        access(32'hA000_0000);
        expect_res("R5 enabled w7", 1'b1, 7, 5, 8'h77, 32'hA000_0000);
        access(32'h9000_1234);
        expect_res("R3 w1 over w7", 1'b1, 1, 4, 8'hE0, 32'hC000_1234);
        access(32'h7FFF_0001);
        expect_res("R1 w7 catch-all", 1'b1, 7, 5, 8'h77, 32'h7FFF_0001);

        // R8 identity on window 3 after setting remap lo = base
        wr(3, 2, 32'hB000_0000);
        access(32'hB002_5678);
        expect_res("R8 identity w3", 1'b1, 3, 2, 8'h55, 32'hB002_5678);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule